// File: doc/BRIEF.md
# Write-Invalidate Snooping Coherence Controller

This block holds the coherence state and tag of every line of a small write-back cache that sits on a shared snooping bus. Each line is Invalid, Shared (clean, read-only, possibly held elsewhere) or Exclusive (dirty, read/write, held only here). On every clock it can take one event from the local processor (read or write to a line index with a tag) and one event snooped from the bus (another cache's read miss or write miss to an index and tag). It updates the line states and tags, issues the bus command that the processor event requires, and raises write-back strobes when a dirty block must leave the cache.

The processor event is classified as a hit or a miss here, from the stored tag and state. Data storage, bus arbitration and the data path of the write-back are outside the block. The strobes and tags it emits tell the data side which block to move. All outputs are registered and appear one clock after the edge that samples the request.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid and every output is zero. The state codes are Invalid=0, Shared=1, Exclusive=2.
- R2: A processor request hits only when the stored tag of the indexed line equals the request tag and that line is not Invalid. `cpu_hit_o` reports this one cycle later, and is 0 when there was no request.
- R3: A processor read to an Invalid line issues a read miss (bus code 1) and leaves the line Shared. A processor write to an Invalid line issues a write miss (bus code 2) and leaves it Exclusive. In both cases the request tag is stored. Bus code 0 means no command.
- R4: For a Shared line, a read hit issues nothing. A read miss issues a read miss, stores the new tag and stays Shared, with no write-back. A write, hit or miss, issues a write miss and moves to Exclusive.
- R5: For an Exclusive line, read hits and write hits issue no bus command and leave the line Exclusive.
- R6: For an Exclusive line, a processor miss raises `cpu_wb_o` with the old tag on `cpu_wb_tag_o`. A read miss then issues a read miss and moves to Shared. A write miss issues a write miss and stays Exclusive.
- R7: A snooped write miss (code 2) matching a Shared line invalidates it. A snooped read miss (code 1) leaves a Shared line unchanged.
- R8: A snooped read miss matching an Exclusive line raises `snp_wb_o` with that tag and moves the line to Shared. A snooped write miss does the same write-back and moves the line to Invalid.
- R9: A snoop whose tag differs from the stored tag, or that targets an Invalid line, changes nothing and raises no strobe.
- R10: When a snoop and a processor request hit the same line in one cycle, the snoop's effect is applied first and the processor request is judged on the resulting state.
- R11: Outputs are registered. Bus command, tags, strobes and `line_state_o` (the post-update state of the line at `cpu_idx_i`) describe the cycle sampled at the previous edge. A write-back strobe appears in the same cycle as the state update it belongs to.
- R12: Lines are independent. A processor write-back on one line and a snoop write-back on another can occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_idx_i | input | IDX_W | Line index of the processor request |
| cpu_tag_i | input | TAG_W | Tag of the processor request |
| snp_cmd_i | input | 2 | Snooped command: 0 none, 1 read miss, 2 write miss |
| snp_idx_i | input | IDX_W | Line index of the snooped command |
| snp_tag_i | input | TAG_W | Tag of the snooped command |
| line_state_o | output | 2 | Post-update state of the processor-indexed line |
| cpu_hit_o | output | 1 | Processor request was a hit |
| bus_cmd_o | output | 2 | Bus command to place: 0 none, 1 read miss, 2 write miss |
| bus_tag_o | output | TAG_W | Tag accompanying the bus command |
| cpu_wb_o | output | 1 | Processor-caused write-back strobe |
| cpu_wb_tag_o | output | TAG_W | Tag of the block written back for the processor |
| snp_wb_o | output | 1 | Snoop-caused write-back strobe |
| snp_wb_tag_o | output | TAG_W | Tag of the block written back for the snoop |

## Verification
Two functions can coincide: a snoop transition and a processor transition, either on the same line or on two different lines. The bench drives both in one cycle. On the same line, an Exclusive line is hit by a snooped write miss while the processor reads it, and the processor must then see a miss after the write-back. On different lines, a snoop write-back and a processor write-back land together. A behavioural reference model applies the snoop before the processor event and is compared with every output on every clock, through directed cases and a long random run that uses few tags, so that collisions are frequent.

// File: rtl/snoop_coh_pkg.sv
package snoop_coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHD = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RDM  = 2'd1,
    BUS_WRM  = 2'd2
  } bus_cmd_e;
endpackage

// File: rtl/snoop_coh_snoop_step.sv
module snoop_coh_snoop_step
  import snoop_coh_pkg::*;
(
  input  line_st_e st_i,
  input  logic     match_i,
  input  bus_cmd_e cmd_i,
  output line_st_e st_o,
  output logic     wb_o
);
  always_comb begin
    st_o = st_i;
    wb_o = 1'b0;
    if (match_i) begin
      unique case (st_i)
        LN_EXC: begin
          wb_o = (cmd_i != BUS_NONE);
          if (cmd_i == BUS_RDM)      st_o = LN_SHD;
          else if (cmd_i == BUS_WRM) st_o = LN_INV;
        end
        LN_SHD:  if (cmd_i == BUS_WRM) st_o = LN_INV;
        default: st_o = st_i;
      endcase
    end
  end
endmodule

// File: rtl/snoop_coh_cpu_step.sv
module snoop_coh_cpu_step
  import snoop_coh_pkg::*;
(
  input  line_st_e st_i,
  input  logic     req_i,
  input  logic     we_i,
  input  logic     hit_i,
  output line_st_e st_o,
  output bus_cmd_e cmd_o,
  output logic     wb_o,
  output logic     take_tag_o
);
  always_comb begin
    st_o       = st_i;
    cmd_o      = BUS_NONE;
    wb_o       = 1'b0;
    take_tag_o = 1'b0;
    if (req_i) begin
      unique case (st_i)
        LN_INV: begin
          cmd_o      = we_i ? BUS_WRM : BUS_RDM;
          st_o       = we_i ? LN_EXC : LN_SHD;
          take_tag_o = 1'b1;
        end
        LN_SHD: begin
          if (we_i) begin
            cmd_o      = BUS_WRM;
            st_o       = LN_EXC;
            take_tag_o = 1'b1;
          end else if (!hit_i) begin
            cmd_o      = BUS_RDM;
            take_tag_o = 1'b1;
          end
        end
        LN_EXC: begin
          if (!hit_i) begin
            wb_o       = 1'b1;
            cmd_o      = we_i ? BUS_WRM : BUS_RDM;
            st_o       = we_i ? LN_EXC : LN_SHD;
            take_tag_o = 1'b1;
          end
        end
        default: st_o = LN_INV;
      endcase
    end
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import snoop_coh_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic [TAG_W-1:0] cpu_tag_i,
  input  logic [1:0]       snp_cmd_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic [1:0]       line_state_o,
  output logic             cpu_hit_o,
  output logic [1:0]       bus_cmd_o,
  output logic [TAG_W-1:0] bus_tag_o,
  output logic             cpu_wb_o,
  output logic [TAG_W-1:0] cpu_wb_tag_o,
  output logic             snp_wb_o,
  output logic [TAG_W-1:0] snp_wb_tag_o
);
  line_st_e         st_q  [NUM_LINES];
  logic [TAG_W-1:0] tag_q [NUM_LINES];

  bus_cmd_e snp_cmd;
  line_st_e snp_st_cur, snp_st_nx, mid_st, cpu_st_nx;
  logic     snp_match, snp_wb, cpu_hit, cpu_wb, take_tag;
  bus_cmd_e cpu_cmd;

  assign snp_cmd    = bus_cmd_e'(snp_cmd_i);
  assign snp_st_cur = st_q[snp_idx_i];
  assign snp_match  = (snp_cmd != BUS_NONE) && (snp_st_cur != LN_INV) &&
                      (tag_q[snp_idx_i] == snp_tag_i);

  snoop_coh_snoop_step u_snp (
    .st_i   (snp_st_cur),
    .match_i(snp_match),
    .cmd_i  (snp_cmd),
    .st_o   (snp_st_nx),
    .wb_o   (snp_wb)
  );

  // snoop effect is applied before the processor request
  assign mid_st  = (snp_idx_i == cpu_idx_i) ? snp_st_nx : st_q[cpu_idx_i];
  assign cpu_hit = (mid_st != LN_INV) && (tag_q[cpu_idx_i] == cpu_tag_i);

  snoop_coh_cpu_step u_cpu (
    .st_i      (mid_st),
    .req_i     (cpu_req_i),
    .we_i      (cpu_we_i),
    .hit_i     (cpu_hit),
    .st_o      (cpu_st_nx),
    .cmd_o     (cpu_cmd),
    .wb_o      (cpu_wb),
    .take_tag_o(take_tag)
  );

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[gi]  <= LN_INV;
        tag_q[gi] <= '0;
      end else if (cpu_req_i && cpu_idx_i == IDX_W'(gi)) begin
        st_q[gi] <= cpu_st_nx;
        if (take_tag) tag_q[gi] <= cpu_tag_i;
      end else if (snp_idx_i == IDX_W'(gi)) begin
        st_q[gi] <= snp_st_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_state_o <= LN_INV;
      cpu_hit_o    <= 1'b0;
      bus_cmd_o    <= BUS_NONE;
      bus_tag_o    <= '0;
      cpu_wb_o     <= 1'b0;
      cpu_wb_tag_o <= '0;
      snp_wb_o     <= 1'b0;
      snp_wb_tag_o <= '0;
    end else begin
      line_state_o <= cpu_st_nx;
      cpu_hit_o    <= cpu_req_i && cpu_hit;
      bus_cmd_o    <= cpu_cmd;
      bus_tag_o    <= cpu_tag_i;
      cpu_wb_o     <= cpu_wb;
      cpu_wb_tag_o <= tag_q[cpu_idx_i];
      snp_wb_o     <= snp_wb;
      snp_wb_tag_o <= snp_tag_i;
    end
  end

  // R6
  cpu_wb_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wb_o |-> (bus_cmd_o != BUS_NONE));
  // R9
  snp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_cmd_i == BUS_NONE) |=> !snp_wb_o);
  // R11
  cpu_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_req_i |=> (bus_cmd_o == BUS_NONE) && !cpu_wb_o && !cpu_hit_o);
  // R3
  write_exc_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_i && cpu_we_i) |=> (line_state_o == LN_EXC));
  // R4
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_i && !cpu_we_i) |=> (line_state_o == LN_SHD || line_state_o == LN_EXC));
  // R2
  read_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_i && !cpu_we_i) |=> (cpu_hit_o == (bus_cmd_o == BUS_NONE)));
endmodule

// File: tb/snoop_coh_ctrl_bench.sv
module snoop_coh_ctrl_bench;
  localparam int NL = 8;
  localparam int TW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst;
  logic cpu_req, cpu_we;
  logic [IW-1:0] cpu_idx, snp_idx;
  logic [TW-1:0] cpu_tag, snp_tag;
  logic [1:0] snp_cmd;
  logic [1:0] line_state;
  logic cpu_hit, cpu_wb, snp_wb;
  logic [1:0] bus_cmd;
  logic [TW-1:0] bus_tag, cpu_wb_tag, snp_wb_tag;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  int m_st [NL];
  int m_tag [NL];
  int e_state, e_cmd, e_btag, e_cwbt, e_swbt;
  bit e_hit, e_cwb, e_swb;

  always #5 clk = ~clk;

  snoop_coh_ctrl #(.NUM_LINES(NL), .TAG_W(TW)) u_snoop_coh_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_idx_i(cpu_idx), .cpu_tag_i(cpu_tag),
    .snp_cmd_i(snp_cmd), .snp_idx_i(snp_idx), .snp_tag_i(snp_tag),
    .line_state_o(line_state), .cpu_hit_o(cpu_hit), .bus_cmd_o(bus_cmd), .bus_tag_o(bus_tag),
    .cpu_wb_o(cpu_wb), .cpu_wb_tag_o(cpu_wb_tag), .snp_wb_o(snp_wb), .snp_wb_tag_o(snp_wb_tag)
  );

  // Behavioural reference: snoop applied first, then the processor request.
  task automatic model(input bit rq, input bit we, input int ci, input int ct,
                       input int sc, input int si, input int st);
    bit hit;
    e_swb = 0; e_cwb = 0; e_cmd = 0; e_hit = 0;
    e_swbt = st; e_btag = ct; e_cwbt = m_tag[ci];
    if (sc != 0 && m_st[si] != 0 && m_tag[si] == st) begin
      if (m_st[si] == 2) begin
        e_swb = 1;
        m_st[si] = (sc == 1) ? 1 : 0;
      end else if (sc == 2) m_st[si] = 0;
    end
    hit = (m_st[ci] != 0) && (m_tag[ci] == ct);
    e_cwbt = m_tag[ci];
    if (rq) begin
      e_hit = hit;
      if (m_st[ci] == 0) begin
        e_cmd = we ? 2 : 1; m_st[ci] = we ? 2 : 1; m_tag[ci] = ct;
      end else if (m_st[ci] == 1) begin
        if (we) begin e_cmd = 2; m_st[ci] = 2; m_tag[ci] = ct; end
        else if (!hit) begin e_cmd = 1; m_tag[ci] = ct; end
      end else if (!hit) begin
        e_cwb = 1; e_cmd = we ? 2 : 1; m_st[ci] = we ? 2 : 1; m_tag[ci] = ct;
      end
    end
    e_state = m_st[ci];
  endtask

  task automatic fail(input string req, input string what, input int act, input int exp);
    bad++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic step(input bit rq, input bit we, input int ci, input int ct,
                      input int sc, input int si, input int st, input string req);
    int b0;
    @(negedge clk);
    cpu_req = rq; cpu_we = we; cpu_idx = IW'(ci); cpu_tag = TW'(ct);
    snp_cmd = 2'(sc); snp_idx = IW'(si); snp_tag = TW'(st);
    model(rq, we, ci, ct, sc, si, st);
    @(posedge clk); #1;
    checks++;
    b0 = bad;
    if (int'(line_state) != e_state) fail(req, "state", line_state, e_state);
    if (cpu_hit != e_hit) fail(req, "hit", cpu_hit, e_hit);
    if (int'(bus_cmd) != e_cmd) fail(req, "bus_cmd", bus_cmd, e_cmd);
    if (e_cmd != 0 && int'(bus_tag) != e_btag) fail(req, "bus_tag", bus_tag, e_btag);
    if (cpu_wb != e_cwb) fail(req, "cpu_wb", cpu_wb, e_cwb);
    if (e_cwb && int'(cpu_wb_tag) != e_cwbt) fail(req, "cpu_wb_tag", cpu_wb_tag, e_cwbt);
    if (snp_wb != e_swb) fail(req, "snp_wb", snp_wb, e_swb);
    if (e_swb && int'(snp_wb_tag) != e_swbt) fail(req, "snp_wb_tag", snp_wb_tag, e_swbt);
    if (bad > b0 + 1) bad = b0 + 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fail("watchdog", "cycles", 150000, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    rst = 1; cpu_req = 0; cpu_we = 0; cpu_idx = 0; cpu_tag = 0;
    snp_cmd = 0; snp_idx = 0; snp_tag = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++; // R1 reset state of outputs
    if (line_state != 0 || cpu_hit || bus_cmd != 0 || cpu_wb || snp_wb || bus_tag != 0)
      fail("R1", "outputs", {line_state, bus_cmd}, 0);
    @(negedge clk); rst = 0;
    step(1, 0, 7, 0, 0, 0, 0, "R1");     // tag 0 on reset line must miss
    step(1, 0, 0, 5, 0, 0, 0, "R3");     // Invalid read -> read miss, Shared
    step(1, 0, 0, 5, 0, 0, 0, "R2");     // read hit
    step(1, 0, 0, 6, 0, 0, 0, "R4");     // Shared read miss, no write-back
    step(1, 1, 0, 6, 0, 0, 0, "R4");     // Shared write -> Exclusive
    step(1, 1, 0, 6, 0, 0, 0, "R5");     // Exclusive write hit
    step(1, 0, 0, 6, 0, 0, 0, "R5");     // Exclusive read hit
    step(1, 0, 0, 7, 0, 0, 0, "R6");     // Exclusive read miss, write-back of 6
    step(1, 1, 1, 3, 0, 0, 0, "R3");     // Invalid write -> Exclusive
    step(1, 1, 1, 4, 0, 0, 0, "R6");     // Exclusive write miss, write-back of 3
    step(0, 0, 1, 0, 2, 1, 9, "R9");     // mismatching snoop ignored
    step(1, 0, 1, 4, 0, 0, 0, "R9");     // still Exclusive hit
    step(0, 0, 6, 0, 2, 6, 0, "R9");     // snoop to Invalid line ignored
    step(0, 0, 1, 0, 1, 1, 4, "R8");     // snooped read miss on Exclusive
    step(1, 0, 1, 4, 0, 0, 0, "R8");     // now Shared hit
    step(0, 0, 0, 0, 1, 0, 7, "R7");     // snooped read miss on Shared: no change
    step(1, 0, 0, 7, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 2, 0, 7, "R7");     // snooped write miss invalidates
    step(1, 0, 0, 7, 0, 0, 0, "R7");     // read misses again
    step(1, 1, 2, 1, 0, 0, 0, "R3");
    step(0, 0, 2, 0, 2, 2, 1, "R8");     // snooped write miss on Exclusive
    step(1, 0, 2, 1, 0, 0, 0, "R8");     // Invalid now: read miss
    step(1, 1, 3, 2, 0, 0, 0, "R3");
    step(1, 0, 3, 2, 2, 3, 2, "R10");    // same line, same cycle
    step(1, 1, 4, 1, 0, 0, 0, "R12");
    step(1, 1, 5, 1, 0, 0, 0, "R12");
    step(1, 0, 5, 2, 1, 4, 1, "R12");    // two write-backs in one cycle
    step(1, 1, 6, 3, 1, 6, 3, "R10");    // snoop misses Invalid line, cpu write
    for (int n = 0; n < 4000; n++) begin
      int sc;
      sc = $urandom_range(0, 2);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, NL - 1),
           $urandom_range(0, 3), sc, $urandom_range(0, NL - 1), $urandom_range(0, 3), "R11");
    end
    finish_run();
  end
endmodule